// File: doc/BRIEF.md
# Windowed Framebuffer Fetch Engine

This block fetches the pixel words of one visible window out of a wider virtual framebuffer held in memory and stores them in an on-chip pixel FIFO. The display timing logic drains that FIFO. Software supplies five settings: a start address, a byte count to skip at the end of each visible line, the visible line length in words, the frame length in words, and the burst size. It also supplies a sub-word bit offset, which the display side uses on the first word of every line.

Settings are held in a shadow stage. A write only updates the shadow copy. An update strobe then arms a transfer, and the engine copies the shadow into its working set when it accepts the next frame-start pulse. The engine issues burst reads on a request/grant port and then receives the read data one beat per valid cycle. A new burst is requested only when the FIFO has enough free room.

Two sticky flags report faults: one for a FIFO underflow and one for a settings write made while an update was still pending. A busy output shows whether the fetch engine has fully stopped.

Top module: `fb2d_fetch`

## Requirements
- R1: The first burst of every frame reads from the start address with its two low bits cleared. Every request address is word aligned.
- R2: When a visible line of `cfg_line_words` words has been requested, the next line starts at the old line start + 4 × `cfg_line_words` + `cfg_skip` bytes, with the two low bits then cleared.
- R3: `rd_len` holds the burst word count minus one. Each burst is the smallest of `cfg_burst_m1`+1, the words left in the line and the words left in the frame. A burst never spans two lines.
- R4: Each frame fetches exactly `cfg_frame_words` words. After the last request of a frame, no request is issued until the next `frame_start`, and the new frame starts again at the start address.
- R5: A burst is requested only while the FIFO fill level is at or below DEPTH − (2 × (`cfg_burst_m1`+1) + 3). With the FIFO not drained, the level therefore settles above that threshold and at most one burst beyond it.
- R6: A `cfg_wr` that is not followed by `cfg_upd` has no effect on fetching or on `pix_bitoff`. After `cfg_upd`, the new settings take effect at the next frame start that the engine accepts.
- R7: A `cfg_wr` made while an update is pending sets `overwrite`. The flag stays set until `flag_clr` is pulsed.
- R8: Popping an empty FIFO sets `underflow`. The flag stays set until `flag_clr` is pulsed.
- R9: `busy` is low after reset. It stays high while the engine is enabled. After `enable` falls, `busy` stays high until the last beat of any burst already granted has arrived, and no request follows.
- R10: `pix_sol` is 1 on the first word of each visible line and 0 on all other words. `pix_bitoff` reports the bit offset of the active settings.
- R11: `rd_req` stays high with a stable address and length until `rd_gnt` is seen. Read data is one cycle behind `pix_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Fetch enable |
| frame_start | input | 1 | Frame-start pulse from the display timing |
| cfg_wr | input | 1 | Capture the cfg_* inputs into the shadow stage |
| cfg_upd | input | 1 | Arm loading of the shadow stage at the next frame start |
| flag_clr | input | 1 | Clear the sticky flags |
| cfg_base | input | 32 | Start byte address |
| cfg_skip | input | 16 | Bytes skipped after each visible line |
| cfg_bitoff | input | 5 | First valid bit in the first word of a line |
| cfg_frame_words | input | 24 | Words per frame |
| cfg_line_words | input | 16 | Words per visible line |
| cfg_burst_m1 | input | 4 | Burst words minus one |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | 32 | Burst byte address |
| rd_len | output | 4 | Burst words minus one |
| rd_gnt | input | 1 | Request accepted |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| pix_pop | input | 1 | Pop one word from the pixel FIFO |
| pix_data | output | 32 | Popped word |
| pix_sol | output | 1 | Popped word starts a line |
| pix_empty | output | 1 | Pixel FIFO empty |
| pix_bitoff | output | 5 | Active bit offset |
| busy | output | 1 | Engine not idle |
| underflow | output | 1 | Sticky FIFO underflow |
| overwrite | output | 1 | Sticky pending-update overwrite |

## Verification
A wrong line counter or skip sum shows up at the grant of the next burst: the request address or length differs from the bench's own line walk, and the data of every word after that point no longer matches. A wrong start-of-line tag appears at the first FIFO pop of the affected line. A shadow stage that loads too early changes `pix_bitoff` and the fetched addresses in the very next frame instead of waiting for the update. A threshold that is wrong by more than one burst makes the settled fill level leave its allowed window within a few hundred cycles of the FIFO going undrained.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int SKW = 16;
  localparam int LW  = 16;
  localparam int FW  = 24;
  localparam int BLW = 4;
  localparam int OFW = 5;

  typedef struct packed {
    logic [AW-1:0]  base;
    logic [SKW-1:0] skip;
    logic [OFW-1:0] bitoff;
    logic [FW-1:0]  frame_words;
    logic [LW-1:0]  line_words;
    logic [BLW-1:0] burst_m1;
  } fbf_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAITFS, ST_REQ, ST_DATA} fbf_state_t;
endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 512,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [PW:0]      count,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic             do_pop;

  always_comb begin
    empty  = (count == '0);
    do_pop = pop && !empty;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push)   wptr <= wptr + 1'b1;
      if (do_pop) rptr <= rptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fbf_shadow.sv
module fbf_shadow
  import fbf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_wr,
  input  logic     cfg_upd,
  input  logic     fs_take,
  input  logic     flag_clr,
  input  fbf_cfg_t cfg_in,
  output fbf_cfg_t act_cfg,
  output fbf_cfg_t take_cfg,
  output logic     pending,
  output logic     ovw
);
  fbf_cfg_t shadow;

  // what the engine latches when it accepts a frame start
  always_comb take_cfg = pending ? shadow : act_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow  <= '0;
      act_cfg <= '0;
      pending <= 1'b0;
      ovw     <= 1'b0;
    end else begin
      if (cfg_wr) shadow <= cfg_in;
      if (fs_take && pending) act_cfg <= shadow;
      if (cfg_upd)      pending <= 1'b1;
      else if (fs_take) pending <= 1'b0;
      if (cfg_wr && pending) ovw <= 1'b1;
      else if (flag_clr)     ovw <= 1'b0;
    end
  end
endmodule

// File: rtl/fbf_engine.sv
module fbf_engine
  import fbf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           frame_start,
  input  fbf_cfg_t       act_cfg,
  input  fbf_cfg_t       take_cfg,
  input  logic [CW-1:0]  fifo_count,
  input  logic           rd_gnt,
  input  logic           rd_valid,
  output logic           fs_take,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  output logic [BLW-1:0] rd_len,
  output logic           push,
  output logic           push_sol,
  output logic           busy
);
  fbf_state_t     state;
  logic [AW-1:0]  cur_addr, addr_step;
  logic [LW-1:0]  line_left, line_rem;
  logic [FW-1:0]  frame_left, n_w, ng;
  logic [BLW:0]   beats;
  logic           sol_pend;
  logic [CW-1:0]  thr;
  logic           unused_bits;

  assign unused_bits = ^{take_cfg.skip, take_cfg.bitoff, take_cfg.burst_m1,
                         act_cfg.base, act_cfg.frame_words, act_cfg.bitoff};

  always_comb begin
    thr = CW'(DEPTH - 2 * (int'(act_cfg.burst_m1) + 1) - 3);
    n_w = FW'(act_cfg.burst_m1) + FW'(1);
    if (FW'(line_left) < n_w) n_w = FW'(line_left);
    if (frame_left < n_w)     n_w = frame_left;
    ng        = FW'(rd_len) + FW'(1);
    line_rem  = line_left - LW'(ng);
    addr_step = cur_addr + (AW'(ng) << 2);
    fs_take   = (state == ST_WAITFS) && enable && frame_start;
    push      = (state == ST_DATA) && rd_valid;
    push_sol  = sol_pend;
    busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      rd_len     <= '0;
      cur_addr   <= '0;
      line_left  <= '0;
      frame_left <= '0;
      beats      <= '0;
      sol_pend   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (enable) state <= ST_WAITFS;
        ST_WAITFS: begin
          if (!enable) state <= ST_IDLE;
          else if (frame_start) begin
            cur_addr   <= take_cfg.base & ~AW'(3);
            line_left  <= take_cfg.line_words;
            frame_left <= take_cfg.frame_words;
            state      <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_req) begin
            if (rd_gnt) begin
              rd_req     <= 1'b0;
              beats      <= (BLW+1)'(ng);
              sol_pend   <= (line_left == act_cfg.line_words);
              frame_left <= frame_left - ng;
              if (line_rem == '0) begin
                cur_addr  <= (addr_step + AW'(act_cfg.skip)) & ~AW'(3);
                line_left <= act_cfg.line_words;
              end else begin
                cur_addr  <= addr_step;
                line_left <= line_rem;
              end
              state <= ST_DATA;
            end
          end else if (!enable) begin
            state <= ST_IDLE;
          end else if (frame_left == '0) begin
            state <= ST_WAITFS;
          end else if (fifo_count <= thr) begin
            rd_req  <= 1'b1;
            rd_addr <= cur_addr;
            rd_len  <= BLW'(n_w - FW'(1));
          end
        end
        ST_DATA: begin
          if (rd_valid) begin
            sol_pend <= 1'b0;
            beats    <= beats - 1'b1;
            if (beats == (BLW+1)'(1)) begin
              if (!enable)              state <= ST_IDLE;
              else if (frame_left == '0) state <= ST_WAITFS;
              else                      state <= ST_REQ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fb2d_fetch.sv
module fb2d_fetch
  import fbf_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int CW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           frame_start,
  input  logic           cfg_wr,
  input  logic           cfg_upd,
  input  logic           flag_clr,
  input  logic [AW-1:0]  cfg_base,
  input  logic [SKW-1:0] cfg_skip,
  input  logic [OFW-1:0] cfg_bitoff,
  input  logic [FW-1:0]  cfg_frame_words,
  input  logic [LW-1:0]  cfg_line_words,
  input  logic [BLW-1:0] cfg_burst_m1,
  output logic           rd_req,
  output logic [AW-1:0]  rd_addr,
  output logic [BLW-1:0] rd_len,
  input  logic           rd_gnt,
  input  logic           rd_valid,
  input  logic [DW-1:0]  rd_data,
  input  logic           pix_pop,
  output logic [DW-1:0]  pix_data,
  output logic           pix_sol,
  output logic           pix_empty,
  output logic [OFW-1:0] pix_bitoff,
  output logic           busy,
  output logic           underflow,
  output logic           overwrite
);
  fbf_cfg_t      cfg_in, act_cfg, take_cfg;
  logic          fs_take, push, push_sol, unused_pending;
  logic [CW-1:0] fifo_count;

  assign cfg_in = '{base: cfg_base, skip: cfg_skip, bitoff: cfg_bitoff,
                    frame_words: cfg_frame_words, line_words: cfg_line_words,
                    burst_m1: cfg_burst_m1};
  assign pix_bitoff = act_cfg.bitoff;

  fbf_shadow u_shadow (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_upd(cfg_upd),
    .fs_take(fs_take), .flag_clr(flag_clr), .cfg_in(cfg_in),
    .act_cfg(act_cfg), .take_cfg(take_cfg), .pending(unused_pending),
    .ovw(overwrite)
  );

  fbf_engine #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_engine (
    .clk(clk), .rst(rst), .enable(enable), .frame_start(frame_start),
    .act_cfg(act_cfg), .take_cfg(take_cfg), .fifo_count(fifo_count),
    .rd_gnt(rd_gnt), .rd_valid(rd_valid), .fs_take(fs_take),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .push(push), .push_sol(push_sol), .busy(busy)
  );

  fbf_fifo #(.WIDTH(DW + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata({push_sol, rd_data}),
    .pop(pix_pop), .rdata({pix_sol, pix_data}), .count(fifo_count),
    .empty(pix_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)                         underflow <= 1'b0;
    else if (pix_pop && pix_empty)   underflow <= 1'b1;
    else if (flag_clr)               underflow <= 1'b0;
  end
endmodule

// File: rtl/fb2d_fetch_chk.sv
module fb2d_fetch_chk #(
  parameter int DEPTH = 512,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic          rd_req,
  input logic          rd_gnt,
  input logic [31:0]   rd_addr,
  input logic [3:0]    rd_len,
  input logic          busy,
  input logic          underflow,
  input logic          overwrite,
  input logic          flag_clr,
  input logic [3:0]    burst_m1,
  input logic [CW-1:0] level
);
  logic [CW-1:0] thr;
  assign thr = CW'(DEPTH - 2 * (int'(burst_m1) + 1) - 3);

  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[1:0] == 2'b00);
  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_len <= burst_m1);
  // R5
  fill_thr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> level <= thr);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr) && $stable(rd_len));
  // R8
  udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow && !flag_clr |=> underflow);
  // R7
  ovw_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overwrite && !flag_clr |=> overwrite);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(enable));
endmodule

bind fb2d_fetch fb2d_fetch_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .enable(enable), .rd_req(rd_req), .rd_gnt(rd_gnt),
  .rd_addr(rd_addr), .rd_len(rd_len), .busy(busy), .underflow(underflow),
  .overwrite(overwrite), .flag_clr(flag_clr), .burst_m1(act_cfg.burst_m1),
  .level(fifo_count)
);

// File: tb/test_fb2d_fetch.sv
module test_fb2d_fetch;
  logic clk = 1'b0, rst = 1'b1;
  logic enable = 0, frame_start = 0, cfg_wr = 0, cfg_upd = 0, flag_clr = 0;
  logic [31:0] cfg_base = 0;
  logic [15:0] cfg_skip = 0, cfg_line_words = 0;
  logic [4:0]  cfg_bitoff = 0;
  logic [23:0] cfg_frame_words = 0;
  logic [3:0]  cfg_burst_m1 = 0;
  logic rd_req, rd_gnt = 0, rd_valid = 0, pix_pop = 0;
  logic [31:0] rd_addr, rd_data = 0, pix_data;
  logic [3:0]  rd_len;
  logic pix_sol, pix_empty, busy, underflow, overwrite;
  logic [4:0] pix_bitoff;

  int checks = 0, fails = 0, delivered = 0, popped = 0;
  bit mon_en = 1, mon_chk = 1, mem_chk = 1, force_pop = 0;
  logic [32:0] exp_words[$];
  logic [35:0] exp_bursts[$];

  always #4 clk = ~clk;

  fb2d_fetch i_fb2d_fetch (
    .clk(clk), .rst(rst), .enable(enable), .frame_start(frame_start),
    .cfg_wr(cfg_wr), .cfg_upd(cfg_upd), .flag_clr(flag_clr),
    .cfg_base(cfg_base), .cfg_skip(cfg_skip), .cfg_bitoff(cfg_bitoff),
    .cfg_frame_words(cfg_frame_words), .cfg_line_words(cfg_line_words),
    .cfg_burst_m1(cfg_burst_m1), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .pix_pop(pix_pop), .pix_data(pix_data), .pix_sol(pix_sol),
    .pix_empty(pix_empty), .pix_bitoff(pix_bitoff), .busy(busy),
    .underflow(underflow), .overwrite(overwrite)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard driver: expected bursts (R1 R2 R3) and words (R10)
  task automatic gen_frame(input logic [31:0] base, input int lw, input int skip,
                           input int fw, input int bm1);
    logic [31:0] ls = base & ~32'd3;
    int left = fw;
    while (left > 0) begin
      int inl = (lw < left) ? lw : left;
      int pos = 0;
      while (pos < inl) begin
        int n = bm1 + 1;
        if (n > inl - pos) n = inl - pos;
        exp_bursts.push_back({4'(n - 1), ls + 32'(4 * pos)});
        for (int i = 0; i < n; i++)
          exp_words.push_back({(pos + i == 0), mdata(ls + 32'(4 * (pos + i)))});
        pos += n;
      end
      left -= inl;
      ls = (ls + 32'(4 * lw + skip)) & ~32'd3;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] b, input int sk, input int off,
                         input int fw, input int lw, input int bm1);
    cfg_base = b; cfg_skip = 16'(sk); cfg_bitoff = 5'(off);
    cfg_frame_words = 24'(fw); cfg_line_words = 16'(lw); cfg_burst_m1 = 4'(bm1);
    pulse(cfg_wr);
  endtask

  task automatic wait_done();
    while (exp_words.size() != 0 || exp_bursts.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // memory model
  initial begin : mem_model
    logic [31:0] a;
    logic [3:0] l;
    logic [35:0] b;
    forever begin
      @(negedge clk);
      if (rd_req && !rst) begin
        rd_gnt = 1'b1; a = rd_addr; l = rd_len;
        if (mem_chk) begin
          if (exp_bursts.size() == 0) chk(0, "R1 R2 R3 R4 extra burst", {l, a}, 0);
          else begin
            b = exp_bursts.pop_front();
            chk(b == {l, a}, "R1 R2 R3 burst", {l, a}, b);
          end
        end
        @(negedge clk);
        rd_gnt = 1'b0;
        for (int i = 0; i <= int'(l); i++) begin
          rd_valid = 1'b1; rd_data = mdata(a + 32'(4 * i)); delivered++;
          @(negedge clk);
        end
        rd_valid = 1'b0;
      end
    end
  end

  // monitor
  initial begin : monitor
    bit pend = 0;
    logic [32:0] e;
    forever begin
      @(negedge clk);
      if (pend && mon_chk) begin
        if (exp_words.size() == 0) chk(0, "R4 extra word", {pix_sol, pix_data}, 0);
        else begin
          e = exp_words.pop_front();
          chk(e == {pix_sol, pix_data}, "R2 R10 word", {pix_sol, pix_data}, e);
        end
      end
      pend = 0;
      if ((mon_en && !pix_empty) || force_pop) begin
        pix_pop = 1'b1;
        pend = !pix_empty;
        if (!pix_empty) popped++;
      end else pix_pop = 1'b0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit seen;
    int cnt, lvl;
    mon_en = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R9 reset busy", busy, 0);
    chk(rd_req == 0, "R11 reset req", rd_req, 0);
    chk(pix_empty == 1, "R8 reset empty", pix_empty, 1);
    chk(underflow == 0, "R8 reset flag", underflow, 0);
    chk(overwrite == 0, "R7 reset flag", overwrite, 0);

    // R8 underflow
    force_pop = 1; repeat (2) @(negedge clk); force_pop = 0; repeat (2) @(negedge clk);
    chk(underflow == 1, "R8 set", underflow, 1);
    repeat (3) @(negedge clk);
    chk(underflow == 1, "R8 sticky", underflow, 1);
    pulse(flag_clr);
    chk(underflow == 0, "R8 clear", underflow, 0);

    // frame A: unaligned base, odd skip, partial last line
    mon_en = 1;
    set_cfg(32'h1002, 6, 13, 30, 12, 7);
    pulse(cfg_upd);
    enable = 1; repeat (3) @(negedge clk);
    gen_frame(32'h1002, 12, 6, 30, 7);
    pulse(frame_start);
    wait_done();
    chk(pix_bitoff == 13, "R10 bitoff", pix_bitoff, 13);

    // R4: idle until frame start, then restart at base
    seen = 0;
    repeat (20) begin @(negedge clk); if (rd_req) seen = 1; end
    chk(!seen, "R4 no request before frame start", seen, 0);
    chk(busy == 1, "R9 busy while enabled", busy, 1);
    gen_frame(32'h1002, 12, 6, 30, 7);
    pulse(frame_start);
    wait_done();

    // R6: write without update has no effect
    set_cfg(32'h2000, 0, 3, 8, 4, 1);
    chk(pix_bitoff == 13, "R6 no early load", pix_bitoff, 13);
    gen_frame(32'h1002, 12, 6, 30, 7);
    pulse(frame_start);
    wait_done();
    chk(pix_bitoff == 13, "R6 unchanged without update", pix_bitoff, 13);

    // R7 overwrite
    pulse(cfg_upd);
    chk(overwrite == 0, "R7 no flag yet", overwrite, 0);
    set_cfg(32'h2000, 0, 3, 8, 4, 1);
    chk(overwrite == 1, "R7 set", overwrite, 1);
    repeat (3) @(negedge clk);
    chk(overwrite == 1, "R7 sticky", overwrite, 1);
    pulse(flag_clr);
    chk(overwrite == 0, "R7 clear", overwrite, 0);

    // R6 load at frame start
    gen_frame(32'h2000, 4, 0, 8, 1);
    pulse(frame_start);
    wait_done();
    chk(pix_bitoff == 3, "R6 loaded", pix_bitoff, 3);

    // R5 threshold with undrained FIFO
    mon_en = 0; repeat (3) @(negedge clk);
    set_cfg(32'h8000, 0, 0, 1000, 64, 7);
    pulse(cfg_upd);
    gen_frame(32'h8000, 64, 0, 1000, 7);
    pulse(frame_start);
    repeat (1500) @(negedge clk);
    lvl = delivered - popped;
    chk(lvl > 493 && lvl <= 501, "R5 settled level", lvl, 496);
    mon_en = 1;
    wait_done();

    // R9 disable mid-burst
    mon_chk = 0; mem_chk = 0;
    pulse(frame_start);
    cnt = 0;
    do begin @(negedge clk); #1; cnt++; end while (!rd_valid && cnt < 200);
    enable = 0;
    chk(busy == 1, "R9 busy during burst", busy, 1);
    cnt = 0;
    while (busy && cnt < 40) begin @(negedge clk); #1; cnt++; end
    chk(busy == 0 && cnt <= 9, "R9 busy drop cycles", cnt, 8);
    seen = 0;
    repeat (20) begin @(negedge clk); if (rd_req) seen = 1; end
    chk(!seen, "R9 no request after disable", seen, 0);
    repeat (20) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule